// File: doc/BRIEF.md
# Store Queue with Writeback Pointer

This block keeps the stores of an out-of-order core in a circular queue. Stores enter at the tail in program order and receive a slot index along with their 16-bit sequence number. Later, the execute stage uses that index to fill in the store's address, byte size and data. The retire logic names a sequence number, and every queued store older than it becomes committed and eligible to be written.

Between the head and the tail runs a third pointer, the writeback pointer. It always sits on the oldest store that may be written and has not yet been sent. That store is offered to a data cache port with a request/ready pair, and only one write is outstanding at a time. When the cache acknowledges the write, the entry is marked completed. The head then releases completed entries from the front of the queue.

On a misprediction, a squash names a sequence number. Every younger store that has not been committed is dropped by pulling the tail back. The queue reports full one entry early, when its occupancy reaches the depth minus one.

Top module: `sq_store_queue`

## Requirements
- R1: After reset, `count` is 0, `full` is 0, `has_stores_to_wb` is 0, `wb_req` is 0, `alloc_idx` is 0 and `alloc_ready` is 1.
- R2: An allocation takes effect at the clock edge where `alloc_valid` and `alloc_ready` are both high. It takes the slot shown on `alloc_idx`, and `count` rises by one after that edge. Successive allocations take slot indices that increase by one modulo DEPTH.
- R3: `full` is high while `count` >= DEPTH-1. `alloc_ready` is low while `full` is high or `squash_valid` is high, and an allocation offered then is ignored: `count` does not rise.
- R4: An execute write (`exec_valid`) stores `exec_addr`, `exec_size` and `exec_data` in entry `exec_idx`. These values appear on `wb_addr`, `wb_size` and `wb_data` when that entry is offered for writeback.
- R5: A commit (`commit_valid`, `commit_seq`) marks as committed every valid entry whose sequence number is older than `commit_seq`. Sequence number a is older than b when (a - b) mod 65536 >= 32768. `has_stores_to_wb` is high while at least one committed store has not yet been issued to the cache.
- R6: `wb_req` is high only when the entry at the writeback pointer is valid, committed and not completed, and no write is outstanding. The write is issued at the edge where `wb_ready` is also high, and the pointer then moves to the next entry. While `wb_ready` is low, the same store stays on offer. Stores are issued oldest first.
- R7: At most one write is outstanding. After an issue, `wb_req` stays low until `wb_ack` arrives.
- R8: Neither commit nor issue frees an entry. An acknowledged write marks its entry completed at the `wb_ack` edge. The head frees that entry at the following edge, so `count` drops one cycle after the acknowledgement.
- R9: A squash (`squash_valid`, `squash_seq`) removes every valid, uncommitted entry younger than `squash_seq`, using the same wrapping comparison as R5. The tail moves back, so the next `alloc_idx` reuses the first removed slot. Committed entries are kept.
- R10: A `wb_ack` that arrives while no write is outstanding has no effect: no entry is completed and `count` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a new store at the tail |
| alloc_seq | input | 16 | Sequence number of the new store |
| alloc_ready | output | 1 | Allocation can be taken this cycle |
| alloc_idx | output | IDX_W | Slot given to the allocating store |
| exec_valid | input | 1 | Execute result write |
| exec_idx | input | IDX_W | Slot being written by execute |
| exec_addr | input | ADDR_W | Store address |
| exec_size | input | SIZE_W | Store size in bytes |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | 16 | Stores older than this become committed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 16 | Uncommitted stores younger than this are removed |
| wb_req | output | 1 | Write offered to the cache |
| wb_ready | input | 1 | Cache port accepts the write |
| wb_addr | output | ADDR_W | Address of the offered write |
| wb_size | output | SIZE_W | Size of the offered write |
| wb_data | output | DATA_W | Data of the offered write |
| wb_ack | input | 1 | Outstanding write has completed |
| count | output | CNT_W | Number of occupied entries |
| full | output | 1 | Occupancy has reached DEPTH-1 |
| has_stores_to_wb | output | 1 | Committed stores are waiting to be issued |

## Verification
The bench builds the queue with DEPTH=4. With that depth the early-full limit of three entries is reached after three allocations, and both the tail and the writeback pointer wrap past slot 3 within one short sequence. Sequence numbers near 65535 drive the wrapping age comparison in both commit and squash. An unsolicited acknowledgement, sent while an uncommitted store sits in the queue, shows whether a stray acknowledgement could complete or free an entry.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SEQ_W = 16;
  typedef logic [SEQ_W-1:0] seq_t;

  // True when a is strictly older than b under wrapping arithmetic.
  function automatic logic seq_older(input seq_t a, input seq_t b);
    seq_t diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction
endpackage

// File: rtl/sq_entry_array.sv
module sq_entry_array
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  seq_t              alloc_seq,
  input  logic              exec_we,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_en,
  input  seq_t              commit_seq,
  input  logic              squash_en,
  input  seq_t              squash_seq,
  input  logic              done_en,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  newly_vec,
  output logic [DEPTH-1:0]  kill_vec,
  output logic              head_done,
  output logic              rd_valid,
  output logic              rd_can_wb,
  output logic              rd_completed,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [SIZE_W-1:0] rd_size,
  output logic [DATA_W-1:0] rd_data
);
  logic [DEPTH-1:0]  valid_vec;
  logic [DEPTH-1:0]  canwb_vec;
  logic [DEPTH-1:0]  done_vec;
  logic [ADDR_W-1:0] addr_arr [DEPTH];
  logic [SIZE_W-1:0] size_arr [DEPTH];
  logic [DATA_W-1:0] data_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              valid_q;
    logic              committed_q;
    logic              canwb_q;
    logic              completed_q;
    seq_t              seq_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [DATA_W-1:0] data_q;
    logic              hit_alloc;
    logic              hit_exec;
    logic              hit_done;
    logic              hit_free;

    assign hit_alloc = alloc_we && (alloc_idx == IDX_W'(g));
    assign hit_exec  = exec_we && (exec_idx == IDX_W'(g));
    assign hit_done  = done_en && (done_idx == IDX_W'(g));
    assign hit_free  = free_en && (head_idx == IDX_W'(g));

    assign newly_vec[g] = valid_q && commit_en && !committed_q &&
                          seq_older(seq_q, commit_seq);
    assign kill_vec[g]  = valid_q && squash_en && !committed_q && !newly_vec[g] &&
                          seq_older(squash_seq, seq_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q     <= 1'b0;
        committed_q <= 1'b0;
        canwb_q     <= 1'b0;
        completed_q <= 1'b0;
      end else if (hit_alloc) begin
        valid_q     <= 1'b1;
        committed_q <= 1'b0;
        canwb_q     <= 1'b0;
        completed_q <= 1'b0;
      end else if (hit_free || kill_vec[g]) begin
        valid_q     <= 1'b0;
        committed_q <= 1'b0;
        canwb_q     <= 1'b0;
        completed_q <= 1'b0;
      end else begin
        if (newly_vec[g]) begin
          committed_q <= 1'b1;
          canwb_q     <= 1'b1;
        end
        if (hit_done && valid_q) begin
          completed_q <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        seq_q  <= alloc_seq;
        size_q <= '0;
      end
      if (hit_exec) begin
        addr_q <= exec_addr;
        size_q <= exec_size;
        data_q <= exec_data;
      end
    end

    assign valid_vec[g] = valid_q;
    assign canwb_vec[g] = canwb_q;
    assign done_vec[g]  = completed_q;
    assign addr_arr[g]  = addr_q;
    assign size_arr[g]  = size_q;
    assign data_arr[g]  = data_q;
  end

  assign head_done    = valid_vec[head_idx] && done_vec[head_idx];
  assign rd_valid     = valid_vec[rd_idx];
  assign rd_can_wb    = canwb_vec[rd_idx];
  assign rd_completed = done_vec[rd_idx];
  assign rd_addr      = addr_arr[rd_idx];
  assign rd_size      = size_arr[rd_idx];
  assign rd_data      = data_arr[rd_idx];
endmodule

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             free_fire,
  input  logic [CNT_W-1:0] kill_cnt,
  output logic [IDX_W-1:0] head_q,
  output logic [IDX_W-1:0] tail_q,
  output logic [CNT_W-1:0] count_q,
  output logic             full
);
  function automatic logic [IDX_W-1:0] ptr_fwd(input logic [IDX_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  function automatic logic [IDX_W-1:0] ptr_back(input logic [IDX_W-1:0] p, input int n);
    int s;
    s = int'(p) + DEPTH - n;
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  logic [IDX_W-1:0] head_d;
  logic [IDX_W-1:0] tail_d;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    head_d  = free_fire ? ptr_fwd(head_q, 1) : head_q;
    tail_d  = ptr_fwd(ptr_back(tail_q, int'(kill_cnt)), alloc_fire ? 1 : 0);
    count_d = count_q + CNT_W'(alloc_fire) - CNT_W'(free_fire) - kill_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign full = (int'(count_q) >= DEPTH - 1);
endmodule

// File: rtl/sq_wb_ctrl.sv
module sq_wb_ctrl #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic             rd_can_wb,
  input  logic             rd_completed,
  input  logic             wb_ready,
  input  logic             wb_ack,
  input  logic [CNT_W-1:0] newly_cnt,
  output logic [IDX_W-1:0] wb_ptr_q,
  output logic             wb_req,
  output logic             inflight_q,
  output logic             done_en,
  output logic [IDX_W-1:0] done_idx,
  output logic             has_to_wb
);
  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    int s;
    s = int'(p) + 1;
    if (s >= DEPTH) s = 0;
    return IDX_W'(s);
  endfunction

  logic             wb_fire;
  logic [IDX_W-1:0] flight_idx_q;
  logic [CNT_W-1:0] pending_q;

  assign wb_req   = rd_valid && rd_can_wb && !rd_completed && !inflight_q;
  assign wb_fire  = wb_req && wb_ready;
  assign done_en  = inflight_q && wb_ack;
  assign done_idx = flight_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ptr_q     <= '0;
      inflight_q   <= 1'b0;
      flight_idx_q <= '0;
      pending_q    <= '0;
    end else begin
      pending_q <= pending_q + newly_cnt - CNT_W'(wb_fire);
      if (wb_fire) begin
        inflight_q   <= 1'b1;
        flight_idx_q <= wb_ptr_q;
        wb_ptr_q     <= ptr_next(wb_ptr_q);
      end else if (done_en) begin
        inflight_q <= 1'b0;
      end
    end
  end

  assign has_to_wb = (pending_q != '0);
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [15:0]       alloc_seq,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_valid,
  input  logic [15:0]       commit_seq,
  input  logic              squash_valid,
  input  logic [15:0]       squash_seq,
  output logic              wb_req,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SIZE_W-1:0] wb_size,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_ack,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              has_stores_to_wb
);
  logic             alloc_fire;
  logic             free_fire;
  logic [DEPTH-1:0] newly_vec;
  logic [DEPTH-1:0] kill_vec;
  logic [CNT_W-1:0] newly_cnt;
  logic [CNT_W-1:0] kill_cnt;
  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] tail_q;
  logic [IDX_W-1:0] wb_ptr_q;
  logic             inflight;
  logic             done_en;
  logic [IDX_W-1:0] done_idx;
  logic             rd_valid;
  logic             rd_can_wb;
  logic             rd_completed;

  assign alloc_ready = !full && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_q;
  assign newly_cnt   = CNT_W'($countones(newly_vec));
  assign kill_cnt    = CNT_W'($countones(kill_vec));

  sq_entry_array #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)
  ) i_entries (
    .clk(clk), .rst_n(rst_n),
    .alloc_we(alloc_fire), .alloc_idx(tail_q), .alloc_seq(alloc_seq),
    .exec_we(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .exec_size(exec_size), .exec_data(exec_data),
    .commit_en(commit_valid), .commit_seq(commit_seq),
    .squash_en(squash_valid), .squash_seq(squash_seq),
    .done_en(done_en), .done_idx(done_idx),
    .free_en(free_fire), .head_idx(head_q), .rd_idx(wb_ptr_q),
    .newly_vec(newly_vec), .kill_vec(kill_vec), .head_done(free_fire),
    .rd_valid(rd_valid), .rd_can_wb(rd_can_wb), .rd_completed(rd_completed),
    .rd_addr(wb_addr), .rd_size(wb_size), .rd_data(wb_data)
  );

  sq_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_ptrs (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .free_fire(free_fire), .kill_cnt(kill_cnt),
    .head_q(head_q), .tail_q(tail_q), .count_q(count), .full(full)
  );

  sq_wb_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_wb (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_can_wb(rd_can_wb), .rd_completed(rd_completed),
    .wb_ready(wb_ready), .wb_ack(wb_ack), .newly_cnt(newly_cnt),
    .wb_ptr_q(wb_ptr_q), .wb_req(wb_req), .inflight_q(inflight),
    .done_en(done_en), .done_idx(done_idx), .has_to_wb(has_stores_to_wb)
  );
endmodule

// File: rtl/sq_store_queue_checker.sv
module sq_store_queue_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             full,
  input logic [CNT_W-1:0] count,
  input logic             wb_req,
  input logic             wb_ready,
  input logic             inflight,
  input logic             has_stores_to_wb
);
  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH - 1); // R3
  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full && alloc_valid |=> count <= $past(count)); // R3
  AST_REQ_HOLDS_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ready |=> wb_req); // R6
  AST_ISSUE_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inflight) |-> $past(wb_req && wb_ready)); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ready |=> !wb_req); // R7
  AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> has_stores_to_wb); // R5
endmodule

bind sq_store_queue sq_store_queue_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_sq_checker (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .full(full), .count(count),
  .wb_req(wb_req), .wb_ready(wb_ready), .inflight(inflight),
  .has_stores_to_wb(has_stores_to_wb)
);

// File: tb/test_sq_store_queue.sv
module test_sq_store_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 4;
  localparam int IDX_W  = 2;
  localparam int CNT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 1'b0;
  logic [15:0]       alloc_seq = '0;
  logic              alloc_ready;
  logic [IDX_W-1:0]  alloc_idx;
  logic              exec_valid = 1'b0;
  logic [IDX_W-1:0]  exec_idx = '0;
  logic [ADDR_W-1:0] exec_addr = '0;
  logic [SIZE_W-1:0] exec_size = '0;
  logic [DATA_W-1:0] exec_data = '0;
  logic              commit_valid = 1'b0;
  logic [15:0]       commit_seq = '0;
  logic              squash_valid = 1'b0;
  logic [15:0]       squash_seq = '0;
  logic              wb_req;
  logic              wb_ready = 1'b0;
  logic [ADDR_W-1:0] wb_addr;
  logic [SIZE_W-1:0] wb_size;
  logic [DATA_W-1:0] wb_data;
  logic              wb_ack = 1'b0;
  logic [CNT_W-1:0]  count;
  logic              full;
  logic              has_stores_to_wb;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sq_store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_sq_store_queue (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .exec_size(exec_size), .exec_data(exec_data),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .wb_req(wb_req), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_size(wb_size),
    .wb_data(wb_data), .wb_ack(wb_ack),
    .count(count), .full(full), .has_stores_to_wb(has_stores_to_wb)
  );

  function automatic logic [ADDR_W-1:0] addr_of(input logic [15:0] s);
    return 32'h0000_1000 + {14'd0, s, 2'b00};
  endfunction
  function automatic logic [DATA_W-1:0] data_of(input logic [15:0] s);
    return 32'hA500_0000 ^ {16'd0, s};
  endfunction
  function automatic logic [SIZE_W-1:0] size_of(input logic [15:0] s);
    return (s[0]) ? 4'd4 : 4'd2;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic do_alloc(input logic [15:0] s, output logic [IDX_W-1:0] idx, output logic rdy);
    alloc_valid = 1'b1;
    alloc_seq   = s;
    #1;
    idx = alloc_idx;
    rdy = alloc_ready;
    cyc();
    alloc_valid = 1'b0;
  endtask

  task automatic do_exec(input logic [IDX_W-1:0] idx, input logic [15:0] s);
    exec_valid = 1'b1;
    exec_idx   = idx;
    exec_addr  = addr_of(s);
    exec_size  = size_of(s);
    exec_data  = data_of(s);
    cyc();
    exec_valid = 1'b0;
  endtask

  task automatic do_commit(input logic [15:0] s);
    commit_valid = 1'b1;
    commit_seq   = s;
    cyc();
    commit_valid = 1'b0;
  endtask

  task automatic do_squash(input logic [15:0] s);
    squash_valid = 1'b1;
    squash_seq   = s;
    #1;
    check("R3", "alloc_ready during squash", {63'd0, alloc_ready}, 64'd0);
    cyc();
    squash_valid = 1'b0;
  endtask

  task automatic do_issue();
    wb_ready = 1'b1;
    cyc();
    wb_ready = 1'b0;
  endtask

  task automatic do_ack();
    wb_ack = 1'b1;
    cyc();
    wb_ack = 1'b0;
  endtask

  task automatic expect_offer(input string req, input logic [15:0] s);
    check(req, "wb_req", {63'd0, wb_req}, 64'd1);
    check("R4", "wb_addr", {32'd0, wb_addr}, {32'd0, addr_of(s)});
    check("R4", "wb_size", {60'd0, wb_size}, {60'd0, size_of(s)});
    check("R4", "wb_data", {32'd0, wb_data}, {32'd0, data_of(s)});
  endtask

  task automatic t_reset();
    check("R1", "count", {61'd0, count}, 64'd0);
    check("R1", "full", {63'd0, full}, 64'd0);
    check("R1", "has_stores_to_wb", {63'd0, has_stores_to_wb}, 64'd0);
    check("R1", "wb_req", {63'd0, wb_req}, 64'd0);
    check("R1", "alloc_idx", {62'd0, alloc_idx}, 64'd0);
    check("R1", "alloc_ready", {63'd0, alloc_ready}, 64'd1);
  endtask

  task automatic t_fill_and_drain();
    logic [IDX_W-1:0] idx;
    logic rdy;
    for (int i = 0; i < 3; i++) begin
      do_alloc(16'(10 + i), idx, rdy);
      check("R2", "alloc slot", {62'd0, idx}, 64'(i));
      check("R2", "count after alloc", {61'd0, count}, 64'(i + 1));
    end
    check("R3", "full at DEPTH-1", {63'd0, full}, 64'd1);
    do_alloc(16'd13, idx, rdy);
    check("R3", "alloc_ready when full", {63'd0, rdy}, 64'd0);
    check("R3", "count unchanged when full", {61'd0, count}, 64'd3);
    for (int i = 0; i < 3; i++) do_exec(IDX_W'(i), 16'(10 + i));
    check("R5", "no pending before commit", {63'd0, has_stores_to_wb}, 64'd0);
    check("R6", "no req before commit", {63'd0, wb_req}, 64'd0);
    do_commit(16'd12);
    check("R5", "pending after commit", {63'd0, has_stores_to_wb}, 64'd1);
    expect_offer("R6", 16'd10);
    cyc();
    expect_offer("R6", 16'd10);
    do_issue();
    check("R7", "req low while outstanding", {63'd0, wb_req}, 64'd0);
    check("R5", "second store still pending", {63'd0, has_stores_to_wb}, 64'd1);
    check("R8", "not freed at issue", {61'd0, count}, 64'd3);
    cyc();
    check("R7", "req low until ack", {63'd0, wb_req}, 64'd0);
    do_ack();
    expect_offer("R6", 16'd11);
    check("R8", "count at ack edge", {61'd0, count}, 64'd3);
    cyc();
    check("R8", "freed one cycle after ack", {61'd0, count}, 64'd2);
    do_squash(16'd10);
    check("R9", "count after squash", {61'd0, count}, 64'd1);
    check("R9", "tail moved back", {62'd0, alloc_idx}, 64'd2);
    expect_offer("R9", 16'd11);
    do_issue();
    check("R5", "nothing pending after last issue", {63'd0, has_stores_to_wb}, 64'd0);
    do_ack();
    cyc();
    check("R8", "queue empty", {61'd0, count}, 64'd0);
    check("R6", "no req when empty", {63'd0, wb_req}, 64'd0);
  endtask

  task automatic t_seq_wrap();
    logic [IDX_W-1:0] idx;
    logic rdy;
    logic [15:0] seqs [3];
    seqs[0] = 16'hFFFE;
    seqs[1] = 16'hFFFF;
    seqs[2] = 16'h0001;
    for (int i = 0; i < 3; i++) begin
      do_alloc(seqs[i], idx, rdy);
      check("R2", "wrapping slot", {62'd0, idx}, 64'((2 + i) % DEPTH));
      do_exec(idx, seqs[i]);
    end
    do_commit(16'h0001);
    check("R5", "pending after wrap commit", {63'd0, has_stores_to_wb}, 64'd1);
    expect_offer("R6", 16'hFFFE);
    do_issue();
    do_ack();
    expect_offer("R6", 16'hFFFF);
    do_issue();
    do_ack();
    cyc();
    cyc();
    check("R5", "younger store not committed", {63'd0, wb_req}, 64'd0);
    check("R5", "nothing pending", {63'd0, has_stores_to_wb}, 64'd0);
    check("R8", "one entry left", {61'd0, count}, 64'd1);
    do_ack();
    cyc();
    cyc();
    check("R10", "stray ack frees nothing", {61'd0, count}, 64'd1);
    check("R10", "stray ack no req", {63'd0, wb_req}, 64'd0);
    do_squash(16'hFFFF);
    check("R9", "wrap squash empties", {61'd0, count}, 64'd0);
    check("R9", "tail back at slot 0", {62'd0, alloc_idx}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fill_and_drain();
    t_seq_wrap();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule